// File: doc/BRIEF.md
# Byte-Wide Data EEPROM Access Controller

This block lets a small processor reach a 64-byte on-chip data EEPROM through four byte-wide bus registers. Software loads a byte address and, for a store, a data byte. It then starts a cycle through a control register whose start bits act only when a matching enable bit is already set. The controller runs the cycle, clears the start bit by itself when the cycle ends, and for stores latches a completion flag that can drive an interrupt request.

Loads take a short fixed time. Stores take a longer programming time, set by a parameter and counted down internally. A store is accepted only when its start bit is written in the bus access that comes straight after the one that armed write-enable, so one stray write cannot reach the array. While any cycle runs, its address and data are frozen and new start requests are ignored. The storage array is modelled as a register file inside the block.

Top module: `nvbyte_ctrl`

## Requirements
- R1: A load starts only when a bus write to the control register (index 2) has bit 0 (load-start) at 1 while the stored load-enable (control bit 1) is already 1 from an earlier access. If load-enable was 0 before that write, the write starts nothing, and bit 0 reads back 0.
- R2: Control bit 0 reads 1 for exactly RD_CYCLES (2) clock cycles after a load starts, then clears by itself. From that point the data register (index 1) holds the array byte at the latched address.
- R3: The data register keeps the last loaded value, or the last value written to it, until another load or a bus write to it. A change of the address register (index 0) does not alter it.
- R4: A store starts only when a control write has bit 2 (store-start) at 1 and bit 3 (store-enable) at 1, and the previous bus access was a control write that set bit 3 with bit 2 at 0. Setting both bits in one write without that prior access starts nothing.
- R5: Any other bus access, read or write, between the arming control write and the store-start write cancels the store. Idle bus cycles do not cancel it.
- R6: Control bit 2 reads 1 for exactly WR_CYCLES clock cycles after a store starts, then clears by itself. At that point the array byte at the latched address holds the latched data.
- R7: After reset every register reads 0, store-enable included, and irq is 0.
- R8: At the end of every store, the completion flag (bit 0 of register index 3) is set. irq is high only while that flag and the interrupt enable (bit 1 of index 3) are both 1.
- R9: A one-cycle pulse on irq_ack clears the completion flag. Bus writes to index 3 do not change it.
- R10: While a load or store is running, bus writes to the address and data registers and new start requests are ignored. The running cycle uses the address and data latched when it began.
- R11: The address register is 6 bits wide, and bits 7:6 of its readback are 0. Every register reads back over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index: 0 address, 1 data, 2 control, 3 interrupt |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Store-complete interrupt request |

## Verification
A wrong sequencer state shows in the control register readback in the first poll after a start: a start bit that stays set too long or clears too early changes the counted busy cycles at once. A bad operand latch or a lost store shows only later, when the byte is loaded back, so every address is stored and then loaded in a sweep. A broken arming rule or flag path shows in the cycle after the relevant access, as a start bit that should have stayed clear, or as an irq level that is wrong.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    typedef enum logic [1:0] {
        REG_ADDR = 2'd0,
        REG_DATA = 2'd1,
        REG_CTRL = 2'd2,
        REG_IRQ  = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_LOAD,
        OP_STORE
    } op_e;

    localparam int CB_LD_GO = 0;
    localparam int CB_LD_EN = 1;
    localparam int CB_ST_GO = 2;
    localparam int CB_ST_EN = 3;
    localparam int IB_FLAG  = 0;
    localparam int IB_IE    = 1;

    typedef struct packed {
        logic st_en;
        logic st_go;
        logic ld_en;
        logic ld_go;
    } ctrl_bits_t;

    function automatic logic [7:0] ctrl_byte(ctrl_bits_t c);
        return {4'b0000, c};
    endfunction
endpackage

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nvb_seq.sv
module nvb_seq #(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int RD_CYCLES = 2,
    parameter int WR_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_ld,
    input  logic          start_st,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          ld_busy,
    output logic          st_busy,
    output logic          ld_done,
    output logic          st_done,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);
    import nvb_pkg::*;
    localparam int MAXC = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    op_e           state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= OP_IDLE;
            cnt     <= '0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            case (state)
                OP_IDLE: begin
                    if (start_st) begin
                        state   <= OP_STORE;
                        cnt     <= CW'(WR_CYCLES - 1);
                        op_addr <= addr_in;
                        op_data <= data_in;
                    end else if (start_ld) begin
                        state   <= OP_LOAD;
                        cnt     <= CW'(RD_CYCLES - 1);
                        op_addr <= addr_in;
                    end
                end
                default: begin
                    if (cnt == '0) state <= OP_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign ld_busy = (state == OP_LOAD);
    assign st_busy = (state == OP_STORE);
    assign ld_done = ld_busy && (cnt == '0);
    assign st_done = st_busy && (cnt == '0);
endmodule

// File: rtl/nvb_regs.sv
module nvb_regs #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          irq_ack,
    input  logic          ld_busy,
    input  logic          st_busy,
    input  logic          ld_done,
    input  logic          st_done,
    input  logic [DW-1:0] array_rdata,
    output logic          start_ld,
    output logic          start_st,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          ld_en,
    output logic          st_en,
    output logic          arm,
    output logic          flag,
    output logic          irq
);
    import nvb_pkg::*;

    logic       ie;
    logic       busy;
    logic       wr_ctrl;
    ctrl_bits_t wc;
    ctrl_bits_t rc;

    assign busy    = ld_busy || st_busy;
    assign wr_ctrl = bus_sel && bus_we && (reg_idx_e'(bus_addr) == REG_CTRL);
    assign wc      = ctrl_bits_t'(bus_wdata[3:0]);

    assign start_st = wr_ctrl && wc.st_go && wc.st_en && st_en && arm && !busy;
    assign start_ld = wr_ctrl && wc.ld_go && ld_en && !busy && !start_st;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            ld_en  <= 1'b0;
            st_en  <= 1'b0;
            arm    <= 1'b0;
            ie     <= 1'b0;
            flag   <= 1'b0;
        end else begin
            if (bus_sel) arm <= wr_ctrl && wc.st_en && !wc.st_go;
            if (bus_sel && bus_we) begin
                case (reg_idx_e'(bus_addr))
                    REG_ADDR: if (!busy) addr_q <= bus_wdata[AW-1:0];
                    REG_DATA: if (!busy) data_q <= bus_wdata[DW-1:0];
                    REG_CTRL: begin
                        ld_en <= wc.ld_en;
                        st_en <= wc.st_en;
                    end
                    default: ie <= bus_wdata[IB_IE];
                endcase
            end
            if (ld_done) data_q <= array_rdata;
            if (st_done)      flag <= 1'b1;
            else if (irq_ack) flag <= 1'b0;
        end
    end

    always_comb begin
        rc = '{st_en: st_en, st_go: st_busy, ld_en: ld_en, ld_go: ld_busy};
        case (reg_idx_e'(bus_addr))
            REG_ADDR: bus_rdata = 8'(addr_q);
            REG_DATA: bus_rdata = 8'(data_q);
            REG_CTRL: bus_rdata = ctrl_byte(rc);
            default:  bus_rdata = {6'b0, ie, flag};
        endcase
    end

    assign irq = flag && ie;
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl #(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int RD_CYCLES = 2,
    parameter int WR_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_ack,
    output logic       irq
);
    logic          start_ld, start_st;
    logic          ld_busy, st_busy, ld_done, st_done;
    logic [AW-1:0] addr_q, op_addr;
    logic [DW-1:0] data_q, op_data, array_rdata;
    logic          ld_en, st_en, arm, flag;

    nvb_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .ld_busy(ld_busy), .st_busy(st_busy),
        .ld_done(ld_done), .st_done(st_done),
        .array_rdata(array_rdata),
        .start_ld(start_ld), .start_st(start_st),
        .addr_q(addr_q), .data_q(data_q),
        .ld_en(ld_en), .st_en(st_en), .arm(arm), .flag(flag), .irq(irq)
    );

    nvb_seq #(.AW(AW), .DW(DW), .RD_CYCLES(RD_CYCLES), .WR_CYCLES(WR_CYCLES)) u_seq (
        .clk(clk), .rst(rst),
        .start_ld(start_ld), .start_st(start_st),
        .addr_in(addr_q), .data_in(data_q),
        .ld_busy(ld_busy), .st_busy(st_busy),
        .ld_done(ld_done), .st_done(st_done),
        .op_addr(op_addr), .op_data(op_data)
    );

    nvb_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst(rst),
        .we(st_done), .addr(op_addr), .wdata(op_data),
        .rdata(array_rdata)
    );
endmodule

// File: rtl/nvb_chk.sv
module nvb_chk #(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int WR_CYCLES = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_busy,
    input logic          st_busy,
    input logic          ld_en,
    input logic          st_en,
    input logic          arm,
    input logic          flag,
    input logic [AW-1:0] op_addr,
    input logic [DW-1:0] op_data
);
    int unsigned st_run;

    always_ff @(posedge clk) begin
        if (rst)          st_run <= 0;
        else if (st_busy) st_run <= st_run + 1;
        else              st_run <= 0;
    end

    // R1
    ld_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_busy) |-> $past(ld_en));

    // R2
    ld_two_cycles_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ld_busy) |-> ($past(ld_busy) && $past(ld_busy, 2) && !$past(ld_busy, 3)));

    // R4
    st_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_busy) |-> ($past(arm) && $past(st_en)));

    // R6
    st_duration_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_busy) |-> ($past(st_run) == WR_CYCLES - 1));

    // R8
    flag_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_busy) |-> flag);

    // R10
    operands_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_busy || ld_busy) && $past(st_busy || ld_busy)) |-> ($stable(op_addr) && $stable(op_data)));

    // R7
    st_en_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> !st_en);
endmodule

bind nvbyte_ctrl nvb_chk #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .ld_busy(ld_busy), .st_busy(st_busy),
    .ld_en(ld_en), .st_en(st_en), .arm(arm), .flag(flag),
    .op_addr(op_addr), .op_data(op_data)
);

// File: tb/nvbyte_ctrl_bench.sv
module nvbyte_ctrl_bench;
    localparam int WR_CYC = 16;
    localparam int RD_CYC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0;
    logic       irq;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;
    logic [7:0] model [64];

    always #5 clk = ~clk;

    nvbyte_ctrl #(.AW(6), .DW(8), .RD_CYCLES(RD_CYC), .WR_CYCLES(WR_CYC)) u_nvbyte_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic poll(input int bitpos, output int n);
        logic [7:0] v;
        n = 0;
        bus_rd(2'd2, v);
        while (v[bitpos] && n < 1000) begin
            n++;
            bus_rd(2'd2, v);
        end
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic do_load(input int a, output logic [7:0] d, output int n);
        bus_wr(2'd0, 8'(a));
        bus_wr(2'd2, 8'h02);
        bus_wr(2'd2, 8'h03);
        poll(0, n);
        bus_rd(2'd1, d);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                finished = 1;
                compared++; mismatched++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        for (int i = 0; i < 64; i++) model[i] = 8'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R7: reset state
        for (int r = 0; r < 4; r++) begin
            bus_rd(2'(r), v);
            check("R7 reg reset", v, 0);
        end
        check("R7 irq reset", irq, 0);

        // R1: load-start without prior enable
        bus_wr(2'd2, 8'h01);
        bus_rd(2'd2, v);
        check("R1 no enable", v, 0);
        bus_wr(2'd2, 8'h03);
        bus_rd(2'd2, v);
        check("R1 same-write enable", v, 8'h02);

        // R11: address width
        bus_wr(2'd0, 8'hFF);
        bus_rd(2'd0, v);
        check("R11 addr width", v, 8'h3F);

        // R6/R8/R9: store sweep over all addresses
        bus_wr(2'd3, 8'h02);
        for (int a = 0; a < 64; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 5) & 255);
            bus_wr(2'd0, 8'(a));
            bus_wr(2'd1, d);
            bus_wr(2'd2, 8'h08);
            bus_wr(2'd2, 8'h0C);
            poll(2, n);
            model[a] = d;
            check("R6 store busy cycles", n, WR_CYC);
            check("R8 irq raised", irq, 1);
            bus_rd(2'd3, v);
            check("R8 flag reg", v, 8'h03);
            bus_rd(2'd1, v);
            check("R3 data holds stored", v, d);
            bus_wr(2'd3, 8'h02);
            bus_rd(2'd3, v);
            check("R9 bus write keeps flag", v, 8'h03);
            ack_pulse();
            check("R9 irq after ack", irq, 0);
            bus_rd(2'd3, v);
            check("R9 flag cleared", v, 8'h02);
        end

        // R2: load sweep
        for (int a = 0; a < 64; a++) begin
            do_load(a, v, n);
            check("R2 load busy cycles", n, RD_CYC);
            check("R2 load data", v, model[a]);
        end

        // R3: data holds across address change
        do_load(7, v, n);
        bus_wr(2'd0, 8'd9);
        bus_rd(2'd1, v);
        check("R3 hold after addr", v, model[7]);

        // R5: intervening access cancels store
        bus_wr(2'd0, 8'd5);
        bus_wr(2'd1, 8'hAA);
        bus_wr(2'd2, 8'h08);
        bus_rd(2'd0, v);
        bus_wr(2'd2, 8'h0C);
        bus_rd(2'd2, v);
        check("R5 store cancelled", v, 8'h08);
        // R4: both bits in one write without arming
        bus_wr(2'd2, 8'h0C);
        bus_rd(2'd2, v);
        check("R4 no arming", v, 8'h08);
        do_load(5, v, n);
        check("R4 array unchanged", v, model[5]);

        // R5: idle cycles between arming and start keep it
        bus_wr(2'd0, 8'd6);
        bus_wr(2'd1, 8'h5A);
        bus_wr(2'd2, 8'h08);
        repeat (3) @(posedge clk);
        bus_wr(2'd2, 8'h0C);
        poll(2, n);
        model[6] = 8'h5A;
        check("R5 idle keeps arm", n, WR_CYC);
        ack_pulse();
        do_load(6, v, n);
        check("R5 stored after idle", v, 8'h5A);

        // R10 and R8 gating: busy ignores writes and starts, irq masked
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd0, 8'd10);
        bus_wr(2'd1, 8'h11);
        bus_wr(2'd2, 8'h08);
        bus_wr(2'd2, 8'h0C);
        bus_wr(2'd0, 8'd20);
        bus_wr(2'd1, 8'h22);
        bus_wr(2'd2, 8'h0B);
        bus_rd(2'd0, v);
        check("R10 addr ignored", v, 10);
        bus_rd(2'd1, v);
        check("R10 data ignored", v, 8'h11);
        poll(2, n);
        bus_rd(2'd2, v);
        check("R10 start ignored", v, 8'h0A);
        model[10] = 8'h11;
        check("R8 irq masked", irq, 0);
        bus_rd(2'd3, v);
        check("R8 flag without ie", v, 8'h01);
        ack_pulse();
        do_load(10, v, n);
        check("R10 latched store", v, 8'h11);
        do_load(20, v, n);
        check("R10 other addr intact", v, model[20]);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule